// File: doc/BRIEF.md
# Serial accumulator-based LDPC systematic encoder

This block turns one K-bit information block into an N = K + M bit systematic LDPC codeword. The parity-check matrix has a sparse systematic part, with a fixed number of ones in every information column, and a dual-diagonal parity part. Information bits enter one per transfer. Each accepted bit is passed straight to the output stream. It is also XOR-folded into an M-bit projection register at the rows that its column touches. When the last information bit has been taken, a running accumulator with transfer function 1/(1⊕D) turns the projection into parity bits, one per output transfer. The codeword therefore leaves as K information bits followed by M parity bits.

The row positions of each column come from a closed-form rule, so no table is stored. Column c touches rows (c·STEP_COL + j·STEP_ROW) mod M for j = 0..COL_WEIGHT−1. A `start` pulse while the encoder is idle clears the projection and the accumulator and opens the block. The encoder takes no new block until the current codeword has been fully sent. A one-cycle `done` pulse follows the last parity bit.

Back-pressure rules:
- During the information phase the input is ready only when the output is ready, so each input transfer is also an output transfer. `out_valid` then mirrors `in_valid`.
- During the parity phase `out_valid` is held high. `out_bit` stays fixed until `out_ready` takes it.
- `in_ready` is low outside the information phase.

Top module: `ldpc_acc_encoder`

## Requirements
- R1: After reset, `out_valid`, `in_ready` and `done` are 0 and stay 0 until a `start` pulse arrives; `in_valid` alone produces no output.
- R2: After `start` in idle, `in_ready` equals `out_ready` during the information phase; no input is accepted while `out_ready` is 0.
- R3: The first K output transfers carry the accepted information bits unchanged and in arrival order; no input is accepted during the parity phase.
- R4: With defaults K=16, M=16, weight 3, STEP_COL=3, STEP_ROW=5, the projection bit v[r] is the XOR of the info bits c whose rows (3c+5j) mod 16, j=0..2, include r. Output transfer K+i carries p[i] = v[i] XOR p[i−1], with p[0] = v[0].
- R5: `out_last` is 1 on exactly the final output transfer of a codeword (transfer index N−1), and on no other.
- R6: `done` is a one-cycle pulse, high in the cycle right after the final output transfer.
- R7: During the parity phase, while `out_ready` is 0, `out_valid` stays 1 and `out_bit` stays stable.
- R8: `start` clears the projection and the accumulator, so each codeword depends only on its own information bits.
- R9: Every emitted codeword x satisfies H·xᵀ = 0 over GF(2), with H = [Hs | dual-diagonal], where row r of the parity part has ones at columns r and r−1.
- R10: A `start` pulse while a block is in progress has no effect on the codeword being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new block when idle; clears projection |
| in_valid | input | 1 | Information bit present |
| in_ready | output | 1 | Encoder takes the information bit this cycle |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Codeword bit present |
| out_ready | input | 1 | Sink takes the codeword bit this cycle |
| out_bit | output | 1 | Codeword bit (information first, then parity) |
| out_last | output | 1 | Marks the final codeword bit |
| done | output | 1 | One-cycle pulse after the final bit |

## Verification
The bench drives several information patterns:
- An all-zero word shows that no parity appears from nothing.
- Single ones in the first and the last column expose each column's row mapping and the running carry of the accumulator.
- All-ones and alternating words exercise overlapping rows, where contributions cancel.
- Pseudo-random words are run under random input gaps and random output stalls. These separate correct hold and ordering behaviour from handshake slips.

Back-to-back blocks show the clearing effect of `start`. A mid-block `start` shows that it is ignored while busy. Every codeword is also checked against the parity-check equations.

// File: rtl/ldpc_enc_pkg.sv
package ldpc_enc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_PARITY = 2'd2
  } enc_state_e;
endpackage

// File: rtl/ldpc_enc_ctrl.sv
module ldpc_enc_ctrl
  import ldpc_enc_pkg::*;
#(
  parameter int K_BITS = 16,
  parameter int M_BITS = 16,
  localparam int CW = (K_BITS > 1) ? $clog2(K_BITS) : 1,
  localparam int PW = (M_BITS > 1) ? $clog2(M_BITS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic          out_ready,
  output enc_state_e    state,
  output logic [CW-1:0] col_idx,
  output logic [PW-1:0] par_idx,
  output logic          clear,
  output logic          in_fire,
  output logic          par_fire,
  output logic          par_final,
  output logic          done
);
  localparam logic [CW-1:0] COL_END = CW'(K_BITS - 1);
  localparam logic [PW-1:0] PAR_END = PW'(M_BITS - 1);

  assign clear     = (state == ST_IDLE) && start;
  assign in_fire   = (state == ST_LOAD) && in_valid && out_ready;
  assign par_fire  = (state == ST_PARITY) && out_ready;
  assign par_final = (state == ST_PARITY) && (par_idx == PAR_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      col_idx <= '0;
      par_idx <= '0;
      done    <= 1'b0;
    end else begin
      done <= par_fire && par_final;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_LOAD;
            col_idx <= '0;
            par_idx <= '0;
          end
        end
        ST_LOAD: begin
          if (in_fire) begin
            if (col_idx == COL_END) begin
              state   <= ST_PARITY;
              col_idx <= '0;
            end else begin
              col_idx <= col_idx + 1'b1;
            end
          end
        end
        ST_PARITY: begin
          if (par_fire) begin
            if (par_final) begin
              state   <= ST_IDLE;
              par_idx <= '0;
            end else begin
              par_idx <= par_idx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldpc_proj_acc.sv
module ldpc_proj_acc #(
  parameter int K_BITS     = 16,
  parameter int M_BITS     = 16,
  parameter int COL_WEIGHT = 3,
  parameter int STEP_COL   = 3,
  parameter int STEP_ROW   = 5,
  localparam int CW = (K_BITS > 1) ? $clog2(K_BITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              acc_en,
  input  logic              info_bit,
  input  logic [CW-1:0]     col_idx,
  output logic [M_BITS-1:0] proj
);
  logic [M_BITS-1:0] col_rows;

  // Rows hit by the current column: (col*STEP_COL + j*STEP_ROW) mod M.
  for (genvar r = 0; r < M_BITS; r++) begin : g_row
    always_comb begin
      col_rows[r] = 1'b0;
      for (int j = 0; j < COL_WEIGHT; j++) begin
        if (((int'(col_idx) * STEP_COL + j * STEP_ROW) % M_BITS) == r)
          col_rows[r] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  proj <= '0;
    else if (clear)              proj <= '0;
    else if (acc_en && info_bit) proj <= proj ^ col_rows;
  end
endmodule

// File: rtl/ldpc_parity_acc.sv
module ldpc_parity_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic proj_bit,
  output logic par_bit
);
  logic prev_q;

  // 1/(1+D): each parity bit is the projection bit XOR the previous parity bit.
  assign par_bit = proj_bit ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prev_q <= 1'b0;
    else if (clear) prev_q <= 1'b0;
    else if (step)  prev_q <= par_bit;
  end
endmodule

// File: rtl/ldpc_acc_encoder.sv
module ldpc_acc_encoder
  import ldpc_enc_pkg::*;
#(
  parameter int K_BITS     = 16,
  parameter int M_BITS     = 16,
  parameter int COL_WEIGHT = 3,
  parameter int STEP_COL   = 3,
  parameter int STEP_ROW   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_last,
  output logic done
);
  localparam int CW = (K_BITS > 1) ? $clog2(K_BITS) : 1;
  localparam int PW = (M_BITS > 1) ? $clog2(M_BITS) : 1;

  enc_state_e        st;
  logic [CW-1:0]     col_idx;
  logic [PW-1:0]     par_idx;
  logic              clear, in_fire, par_fire, par_final;
  logic [M_BITS-1:0] proj;
  logic              par_bit;

  ldpc_enc_ctrl #(.K_BITS(K_BITS), .M_BITS(M_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .out_ready(out_ready), .state(st), .col_idx(col_idx), .par_idx(par_idx),
    .clear(clear), .in_fire(in_fire), .par_fire(par_fire),
    .par_final(par_final), .done(done)
  );

  ldpc_proj_acc #(
    .K_BITS(K_BITS), .M_BITS(M_BITS), .COL_WEIGHT(COL_WEIGHT),
    .STEP_COL(STEP_COL), .STEP_ROW(STEP_ROW)
  ) u_proj (
    .clk(clk), .rst_n(rst_n), .clear(clear), .acc_en(in_fire),
    .info_bit(in_bit), .col_idx(col_idx), .proj(proj)
  );

  ldpc_parity_acc u_par (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(par_fire),
    .proj_bit(proj[par_idx]), .par_bit(par_bit)
  );

  assign in_ready  = (st == ST_LOAD) && out_ready;
  assign out_valid = ((st == ST_LOAD) && in_valid) || (st == ST_PARITY);
  assign out_bit   = (st == ST_PARITY) ? par_bit : in_bit;
  assign out_last  = par_final;
endmodule

// File: rtl/ldpc_acc_encoder_chk.sv
module ldpc_acc_encoder_chk #(
  parameter int N_BITS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic par_phase,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_last,
  input logic done
);
  int unsigned xfer_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xfer_cnt <= 0;
    else if (out_valid && out_ready) xfer_cnt <= out_last ? 0 : xfer_cnt + 1;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (par_phase && out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  assert_last_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |-> (xfer_cnt == N_BITS - 1));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_input_in_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_last);
endmodule

bind ldpc_acc_encoder ldpc_acc_encoder_chk #(.N_BITS(K_BITS + M_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .par_phase(st == ldpc_enc_pkg::ST_PARITY),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_bit(out_bit), .out_last(out_last), .done(done)
);

// File: tb/tb_ldpc_acc_encoder.sv
module tb_ldpc_acc_encoder;
  localparam int K = 16;
  localparam int M = 16;
  localparam int N = K + M;
  localparam int WT = 3;
  localparam int SC = 3;
  localparam int SR = 5;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, in_bit = 0, out_ready = 0;
  logic in_ready, out_valid, out_bit, out_last, done;

  ldpc_acc_encoder dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .out_last(out_last), .done(done)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit exp_q[$];
  bit rx[N];
  int rx_cnt = 0;
  bit prev_hold = 0, prev_bit = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit hits(input int c, input int r);
    for (int j = 0; j < WT; j++) if (((c * SC + j * SR) % M) == r) return 1;
    return 0;
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Reference stream monitor: compares every output transfer.
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_ready && !out_ready) chk(0, "R2 in_ready while stalled", 1, 0);
      if (prev_hold) begin
        chk(out_valid == 1, "R7 valid held", out_valid, 1);
        chk(out_bit == prev_bit, "R7 bit stable", out_bit, prev_bit);
      end
      prev_hold = out_valid && !out_ready && (rx_cnt >= K);
      prev_bit  = out_bit;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R3 extra output", 1, 0);
        else begin
          bit e;
          e = exp_q.pop_front();
          if (rx_cnt < K) chk(out_bit == e, "R3 info bit", out_bit, e);
          else            chk(out_bit == e, "R4 parity bit", out_bit, e);
        end
        chk(out_last == (rx_cnt == N - 1), "R5 last flag", out_last, rx_cnt == N - 1);
        if (rx_cnt < N) rx[rx_cnt] = out_bit;
        rx_cnt = out_last ? 0 : rx_cnt + 1;
      end
    end
  end

  task automatic run_block(input logic [K-1:0] info, input bit rnd_ready,
                           input bit rnd_valid, input bit poke_start, input string tag);
    bit v[M];
    bit p[M];
    int idx, cyc;
    bit fin;
    for (int r = 0; r < M; r++) begin
      v[r] = 0;
      for (int c = 0; c < K; c++) if (info[c] && hits(c, r)) v[r] = ~v[r];
    end
    for (int i = 0; i < M; i++) p[i] = (i == 0) ? v[0] : (v[i] ^ p[i-1]);
    for (int c = 0; c < K; c++) exp_q.push_back(info[c]);
    for (int i = 0; i < M; i++) exp_q.push_back(p[i]);

    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    idx = 0; cyc = 0; fin = 0;
    while (!fin) begin
      in_valid  = (idx < K) && (!rnd_valid || lfsr[3]);
      in_bit    = (idx < K) ? info[idx] : 1'b0;
      out_ready = !rnd_ready || lfsr[7];
      start     = poke_start && (cyc == K + 3 || cyc == 4); // R10 ignored mid-block
      @(negedge clk);
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready && out_last) fin = 1;
      @(posedge clk); #1;
      cyc++;
      step_lfsr();
    end
    start = 0; in_valid = 0; out_ready = 0;
    @(negedge clk);
    chk(done == 1, {"R6 done pulse ", tag}, done, 1);
    @(posedge clk); #1;
    @(negedge clk);
    chk(done == 0, {"R6 done drops ", tag}, done, 0);
    chk(exp_q.size() == 0, {"R3 all bits sent ", tag}, exp_q.size(), 0);
    // R9: H*x = 0, parity part dual-diagonal.
    for (int r = 0; r < M; r++) begin
      bit s;
      s = rx[K + r];
      if (r > 0) s ^= rx[K + r - 1];
      for (int c = 0; c < K; c++) if (hits(c, r)) s ^= rx[c];
      chk(s == 0, {"R9 syndrome ", tag}, s, 0);
    end
    exp_q.delete();
  endtask

  function automatic logic [K-1:0] rnd_word(input int seed);
    logic [K-1:0] w;
    w = K'(seed * 40503 + 12345);
    return w ^ K'(seed << 5);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 out_ready = 1; in_valid = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    chk(in_ready == 0, "R1 reset in_ready", in_ready, 0);
    chk(done == 0, "R1 reset done", done, 0);
    #1 rst_n = 1;
    repeat (4) begin
      @(negedge clk);
      chk(out_valid == 0 && in_ready == 0, "R1 idle ignores in_valid", out_valid, 0);
    end
    @(posedge clk); #1 in_valid = 0; out_ready = 0;

    run_block('0, 0, 0, 0, "zeros");
    run_block(16'h0001, 0, 0, 0, "first col");
    run_block(16'h8000, 0, 0, 0, "last col");
    run_block('1, 0, 0, 0, "ones");
    run_block(16'h5555, 1, 0, 0, "alt R8 after ones");
    run_block(16'hAAAA, 0, 1, 0, "alt gaps");
    run_block(16'h1234, 1, 1, 1, "R10 poke");
    for (int s = 1; s <= 6; s++) run_block(rnd_word(s), 1, 1, 0, "random stalls");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule